// File: doc/BRIEF.md
# Instruction Breakpoint and Step Counter

This block watches the instruction stream of a processor core. Each cycle it is given the address of the instruction about to execute, a strobe that says an instruction really executes in that cycle, and the interrupt level the core is running at. From these it produces two requests for the debug entry controller. The instruction-breakpoint request is raised when an enabled address comparator matches. The step request is raised when a software-loaded instruction counter overflows.

Software programs four registers through a simple write port and reads them back through a combinational read port. The breakpoint address and its enable are double-buffered. Writes land in a software-visible copy, and the comparator only uses them after a synchronize strobe, which mirrors an instruction-synchronize barrier. The counter advances only while the interrupt level is below a programmable threshold. A threshold of zero therefore turns counting off, and a debug handler that runs at a high level is never counted.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every register reads as zero and both `ibrk_req` and `icnt_req` are low.
- R2: `ibrk_req` is high in the same cycle that `retire_valid` is high, the active enable bit 0 is set and `retire_pc` equals the active breakpoint address on every bit. Otherwise it is low.
- R3: When the active enable bit 0 is clear, an instruction at the breakpoint address raises no `ibrk_req`.
- R4: A write to the breakpoint address or enable is visible on the read port at once. The comparator only uses it after the clock edge at which `sync_strobe` is high. A write made in the same cycle as the strobe is not captured until a later strobe.
- R5: On each clock edge with `retire_valid` high and `cur_level` below the threshold, the counter increases by one. Without `retire_valid` it holds.
- R6: While `cur_level` is at or above the threshold, the counter holds. A threshold of 0 stops counting at every level.
- R7: `icnt_req` is high in a cycle where an instruction is counted while the counter is all ones. At that edge the counter wraps to zero.
- R8: A software write to the counter wins over an increment in the same cycle. The `icnt_req` of that cycle still comes from the old counter value.
- R9: Register select encoding: 0 is the breakpoint address, 1 is the enable (bit 0 only, other bits read zero), 2 is the counter, and 3 is the threshold (low `LVL_W` bits, other bits read zero).
- R10: With the counter loaded with -2 and one counted instruction per cycle, the first instruction raises no request and the second raises `icnt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction executes this cycle |
| retire_pc | input | ADDR_W | Address of that instruction |
| cur_level | input | LVL_W | Current interrupt level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register selected for writing |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_sel | input | 2 | Register selected for reading |
| reg_rd_data | output | DATA_W | Read data (combinational) |
| sync_strobe | input | 1 | Makes the staged breakpoint values active |
| ibrk_req | output | 1 | Instruction-breakpoint request |
| icnt_req | output | 1 | Step counter overflow request |

## Verification
Both requests are combinational. They are due in the cycle where the instruction is presented, so the bench drives `retire_pc` and `retire_valid` just after a rising edge and samples the requests a few nanoseconds later, before the next edge. Counter, register writes and synchronize take effect at the next rising edge, so their results are read through the read port after that edge and before any further stimulus. A staged write is probed in the cycle just after the write, and again after the strobe cycle.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [1:0] {
    SEL_BRK_ADDR = 2'd0,
    SEL_BRK_EN   = 2'd1,
    SEL_STEP_CNT = 2'd2,
    SEL_STEP_LVL = 2'd3
  } dbg_sel_e;
endpackage

// File: rtl/dbg_brk_match.sv
module dbg_brk_match #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_strobe,
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_pc,
  output logic [ADDR_W-1:0] shadow_addr,
  output logic              shadow_en,
  output logic [ADDR_W-1:0] act_addr,
  output logic              act_en,
  output logic              hit
);
  logic [ADDR_W-1:0] shadow_addr_nxt, act_addr_nxt;
  logic              shadow_en_nxt, act_en_nxt;
  logic              shadow_ld, act_ld;
  logic [ADDR_W-1:0] diff;

  // Software-visible copy: loaded by writes
  always_comb begin
    shadow_ld       = wr_addr | wr_en;
    shadow_addr_nxt = shadow_addr;
    shadow_en_nxt   = shadow_en;
    if (wr_addr) shadow_addr_nxt = wr_data[ADDR_W-1:0];
    if (wr_en)   shadow_en_nxt   = wr_data[0];
  end

  // Active copy: loaded from the pre-edge shadow value on sync
  always_comb begin
    act_ld       = sync_strobe;
    act_addr_nxt = shadow_addr;
    act_en_nxt   = shadow_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_addr <= '0;
      shadow_en   <= 1'b0;
    end else if (shadow_ld) begin
      shadow_addr <= shadow_addr_nxt;
      shadow_en   <= shadow_en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr <= '0;
      act_en   <= 1'b0;
    end else if (act_ld) begin
      act_addr <= act_addr_nxt;
      act_en   <= act_en_nxt;
    end
  end

  // Per-bit comparator
  for (genvar b = 0; b < ADDR_W; b++) begin : g_cmp
    assign diff[b] = retire_pc[b] ^ act_addr[b];
  end

  assign hit = retire_valid & act_en & ~(|diff);
endmodule

// File: rtl/dbg_step_cnt.sv
module dbg_step_cnt #(
  parameter int CNT_W  = 32,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              wr_lvl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              retire_valid,
  input  logic [LVL_W-1:0]  cur_level,
  output logic [CNT_W-1:0]  step_cnt,
  output logic [LVL_W-1:0]  step_lvl,
  output logic              ovf_req
);
  logic             counting;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_nxt;
  logic [LVL_W-1:0] lvl_nxt;

  always_comb begin
    counting = retire_valid && (cur_level < step_lvl);
    ovf_req  = counting && (&step_cnt);
    cnt_ld   = wr_cnt | counting;
    if (wr_cnt) cnt_nxt = wr_data[CNT_W-1:0];
    else        cnt_nxt = step_cnt + CNT_W'(1);
    lvl_nxt  = wr_data[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_cnt <= '0;
    else if (cnt_ld) step_cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_lvl <= '0;
    else if (wr_lvl) step_lvl <= lvl_nxt;
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_pc,
  input  logic [LVL_W-1:0]  cur_level,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [1:0]        reg_rd_sel,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              sync_strobe,
  output logic              ibrk_req,
  output logic              icnt_req
);
  dbg_sel_e          wsel, rsel;
  logic              wr_addr, wr_en, wr_cnt, wr_lvl;
  logic [ADDR_W-1:0] shadow_addr, act_addr;
  logic              shadow_en, act_en;
  logic [CNT_W-1:0]  step_cnt;
  logic [LVL_W-1:0]  step_lvl;

  always_comb begin
    wsel    = dbg_sel_e'(reg_wr_sel);
    wr_addr = reg_wr_en && (wsel == SEL_BRK_ADDR);
    wr_en   = reg_wr_en && (wsel == SEL_BRK_EN);
    wr_cnt  = reg_wr_en && (wsel == SEL_STEP_CNT);
    wr_lvl  = reg_wr_en && (wsel == SEL_STEP_LVL);
  end

  dbg_brk_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_brk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_addr     (wr_addr),
    .wr_en       (wr_en),
    .wr_data     (reg_wr_data),
    .sync_strobe (sync_strobe),
    .retire_valid(retire_valid),
    .retire_pc   (retire_pc),
    .shadow_addr (shadow_addr),
    .shadow_en   (shadow_en),
    .act_addr    (act_addr),
    .act_en      (act_en),
    .hit         (ibrk_req)
  );

  dbg_step_cnt #(.CNT_W(CNT_W), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cnt      (wr_cnt),
    .wr_lvl      (wr_lvl),
    .wr_data     (reg_wr_data),
    .retire_valid(retire_valid),
    .cur_level   (cur_level),
    .step_cnt    (step_cnt),
    .step_lvl    (step_lvl),
    .ovf_req     (icnt_req)
  );

  // Read mux, zero-extended
  always_comb begin
    rsel        = dbg_sel_e'(reg_rd_sel);
    reg_rd_data = '0;
    unique case (rsel)
      SEL_BRK_ADDR: reg_rd_data[ADDR_W-1:0] = shadow_addr;
      SEL_BRK_EN:   reg_rd_data[0]          = shadow_en;
      SEL_STEP_CNT: reg_rd_data[CNT_W-1:0]  = step_cnt;
      SEL_STEP_LVL: reg_rd_data[LVL_W-1:0]  = step_lvl;
      default:      reg_rd_data             = '0;
    endcase
  end
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire_valid,
  input logic [LVL_W-1:0]  cur_level,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic              sync_strobe,
  input logic              ibrk_req,
  input logic              icnt_req,
  input logic [CNT_W-1:0]  step_cnt,
  input logic [LVL_W-1:0]  step_lvl,
  input logic [ADDR_W-1:0] shadow_addr,
  input logic [ADDR_W-1:0] act_addr,
  input logic              act_en
);
  logic cnt_wr;
  assign cnt_wr = reg_wr_en && (reg_wr_sel == 2'd2);

  AST_BRK_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ibrk_req |-> (retire_valid && act_en)); // R2

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_strobe |=> ($stable(act_addr) && $stable(act_en))); // R4

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_strobe |=> (act_addr == $past(shadow_addr))); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && (cur_level < step_lvl) && !cnt_wr)
      |=> (step_cnt == $past(step_cnt) + CNT_W'(1))); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!retire_valid || (cur_level >= step_lvl)) && !cnt_wr)
      |=> $stable(step_cnt)); // R6

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt_req && !cnt_wr) |=> (step_cnt == '0)); // R7

  AST_OVF_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_req |-> (retire_valid && (&step_cnt))); // R7
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .retire_valid(retire_valid),
  .cur_level   (cur_level),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_sel  (reg_wr_sel),
  .sync_strobe (sync_strobe),
  .ibrk_req    (ibrk_req),
  .icnt_req    (icnt_req),
  .step_cnt    (step_cnt),
  .step_lvl    (step_lvl),
  .shadow_addr (shadow_addr),
  .act_addr    (act_addr),
  .act_en      (act_en)
);

// File: tb/dbg_trig_unit_test.sv
`timescale 1ns/1ps
module dbg_trig_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_valid;
  logic [31:0] retire_pc;
  logic [3:0]  cur_level;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic [1:0]  reg_rd_sel;
  logic [31:0] reg_rd_data;
  logic        sync_strobe;
  logic        ibrk_req;
  logic        icnt_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dbg_trig_unit uut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .cur_level(cur_level), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .sync_strobe(sync_strobe), .ibrk_req(ibrk_req), .icnt_req(icnt_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic do_sync();
    sync_strobe = 1'b1;
    tick();
    sync_strobe = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [31:0] exp);
    reg_rd_sel = s;
    #1;
    chk(tag, reg_rd_data, exp);
  endtask

  // present one instruction, check the requests in its cycle, then let it execute
  task automatic instr(input string tag, input logic [31:0] pc,
                       input logic eb, input logic ec);
    retire_valid = 1'b1; retire_pc = pc;
    #2;
    chk({tag, " ibrk"}, {31'd0, ibrk_req}, {31'd0, eb});
    chk({tag, " icnt"}, {31'd0, icnt_req}, {31'd0, ec});
    tick();
    retire_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a_addr, b_addr;
    rst_n = 1'b0; retire_valid = 1'b0; retire_pc = '0; cur_level = '0;
    reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0; reg_rd_sel = '0;
    sync_strobe = 1'b0;
    a_addr = 32'h4000_1234;
    b_addr = 32'h8000_0ff0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 ibrk", {31'd0, ibrk_req}, 32'd0);
    chk("R1 icnt", {31'd0, icnt_req}, 32'd0);
    for (int s = 0; s < 4; s++) rd_chk("R1 reg", s[1:0], 32'd0);

    // R4 staged write, no sync yet; R9 readback
    wreg(2'd0, a_addr);
    wreg(2'd1, 32'hffff_ffff);
    rd_chk("R9 addr readback", 2'd0, a_addr);
    rd_chk("R9 enable readback", 2'd1, 32'd1);
    instr("R4 before sync", a_addr, 1'b0, 1'b0);
    do_sync();
    instr("R2 match", a_addr, 1'b1, 1'b0);
    retire_pc = a_addr; #2;
    chk("R2 no retire", {31'd0, ibrk_req}, 32'd0);
    tick();
    for (int b = 0; b < 32; b++)
      instr("R2 one-bit miss", a_addr ^ (32'd1 << b), 1'b0, 1'b0);

    // R3 clear enable; takes effect only after sync (R4)
    wreg(2'd1, 32'd0);
    instr("R4 clear pending", a_addr, 1'b1, 1'b0);
    do_sync();
    instr("R3 disabled", a_addr, 1'b0, 1'b0);

    // R4 write in the same cycle as sync is not captured
    wreg(2'd1, 32'd1);
    do_sync();
    sync_strobe = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = b_addr;
    tick();
    sync_strobe = 1'b0; reg_wr_en = 1'b0;
    instr("R4 same-cycle old addr", a_addr, 1'b1, 1'b0);
    instr("R4 same-cycle new addr", b_addr, 1'b0, 1'b0);
    do_sync();
    instr("R4 later sync new addr", b_addr, 1'b1, 1'b0);
    instr("R4 later sync old addr", a_addr, 1'b0, 1'b0);
    wreg(2'd1, 32'd0);
    do_sync();

    // R10 / R7 load -2, threshold 1, level 0
    cur_level = 4'd0;
    wreg(2'd2, 32'hffff_fffe);
    wreg(2'd3, 32'd1);
    instr("R10 first instr", 32'h100, 1'b0, 1'b0);
    rd_chk("R10 count after first", 2'd2, 32'hffff_ffff);
    instr("R10 second instr", 32'h104, 1'b0, 1'b1);
    rd_chk("R7 wrap to zero", 2'd2, 32'd0);
    instr("R7 after wrap", 32'h108, 1'b0, 1'b0);
    rd_chk("R5 count one", 2'd2, 32'd1);
    tick();
    rd_chk("R5 idle hold", 2'd2, 32'd1);

    // R5 / R6 sweep of every threshold and level
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 16; l++) begin
        wreg(2'd2, 32'd5);
        wreg(2'd3, t);
        cur_level = l[3:0];
        instr("R6 sweep", 32'h200, 1'b0, 1'b0);
        if (l < t) rd_chk("R5 sweep count", 2'd2, 32'd6);
        else       rd_chk("R6 sweep hold", 2'd2, 32'd5);
      end
    end

    // R7 no request when level blocks counting at all ones
    wreg(2'd2, 32'hffff_ffff);
    wreg(2'd3, 32'd3);
    cur_level = 4'd3;
    instr("R7 blocked at all ones", 32'h300, 1'b0, 1'b0);
    rd_chk("R6 blocked hold", 2'd2, 32'hffff_ffff);

    // R8 software write wins over increment
    cur_level = 4'd0;
    retire_valid = 1'b1; retire_pc = 32'h400;
    reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 32'd100;
    #2;
    chk("R8 icnt from old value", {31'd0, icnt_req}, 32'd1);
    tick();
    retire_valid = 1'b0; reg_wr_en = 1'b0;
    rd_chk("R8 write wins", 2'd2, 32'd100);

    // R9 field widths of threshold
    wreg(2'd3, 32'hffff_ffff);
    rd_chk("R9 threshold mask", 2'd3, 32'h0000_000f);
    wreg(2'd3, 32'd0);
    instr("R6 zero threshold", 32'h500, 1'b0, 1'b0);
    rd_chk("R6 zero threshold hold", 2'd2, 32'd100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule